// File: doc/BRIEF.md
# Interrupt-Aware Register Page Stack

This block holds a three-deep stack of 8-bit page selectors for a microcontroller core. The top level is the active page, which the address decoder uses to choose one bank of special-function registers. Under it sit a next level and a last level. When the interrupt controller accepts an interrupt, the stack pushes itself. The active page then becomes a page value that a small lookup table picks from the interrupting source's ID. When the core executes a return-from-interrupt, the stack pops itself. An interrupt routine can therefore reach its own peripheral's registers at once, and the interrupted code gets its page back without saving it in software.

Software can also load any level directly through a write port that takes a level select and a data byte. The three levels come out as plain outputs so the core can read them back. A stack-enable input gates the automatic push. All pins are plain control and data strobes with single-cycle meaning. No data stream crosses this block's edge, so it has no valid/ready handshake and no back-pressure.

Top module: `pgstk_top`

## Requirements
- R1: While reset (`rst_ni` low) is active, and after it is released, all three levels read 0x00.
- R2: With the default parameters, the source-to-page lookup maps ID 3 to 0x0C, ID 5 to 0x00, ID 7 to 0x2A and ID 9 to 0x0F. Every other ID maps to the default page 0x00. The mapped value is what the active page shows after a push.
- R3: An accepted interrupt (`irq_take_i` high with `stk_en_i` high and `ret_i` low) does three things on the next edge: the last level takes the old next level, the next level takes the old active page, and the active page takes the mapped page of `irq_src_i`.
- R4: A return (`ret_i` high with no push in the same cycle) moves the next level into the active page and the last level into the next level. The last level keeps its old value.
- R5: Two nested pushes followed by two pops bring the active page back to its value from before the first push, with the pre-interrupt page held in the last level while both are nested.
- R6: When `stk_en_i` is low, `irq_take_i` leaves all three levels unchanged.
- R7: A push and a return in the same cycle replace only the active page, with the mapped page. The next and last levels keep their values. If `stk_en_i` is low in that cycle, only the pop takes place.
- R8: A software write (`sw_wr_i`) loads `sw_data_i` into the level chosen by `sw_lvl_i` on the next edge. The encoding is 0 = active, 1 = next, 2 = last. The value 3 selects no level, and the write then changes nothing.
- R9: A software write in the same cycle as a push or a pop is dropped. The push or pop alone decides the new levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| stk_en_i | input | 1 | Enables the push on interrupt entry |
| irq_take_i | input | 1 | Interrupt accepted this cycle |
| irq_src_i | input | 4 | ID of the accepted source |
| ret_i | input | 1 | Return-from-interrupt executed this cycle |
| sw_wr_i | input | 1 | Software write strobe |
| sw_lvl_i | input | 2 | Level targeted by the write (0 active, 1 next, 2 last, 3 none) |
| sw_data_i | input | 8 | Write data |
| page_act_o | output | 8 | Active page level |
| page_nxt_o | output | 8 | Next level |
| page_lst_o | output | 8 | Last level |

## Verification
The hardest situation to reach from the ports is a cycle in which several strobes arrive together. Examples are a push and a return on the same edge, or a software write that collides with either. To tell a correct result from a plausible wrong one, all three levels must first hold distinct values. The bench therefore loads distinct bytes into every level through the write port before each collision. It then fires the combined strobes in one cycle and compares all three levels against a model kept in the bench.

// File: rtl/pgstk_pkg.sv
package pgstk_pkg;
  localparam int unsigned LVLS  = 3;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_SWAP = 2'd3
  } stk_op_e;
endpackage

// File: rtl/pgstk_lut.sv
module pgstk_lut #(
  parameter int unsigned SRC_W   = 4,
  parameter int unsigned PAGE_W  = 8,
  parameter int unsigned NUM_MAP = 4,
  parameter logic [NUM_MAP*SRC_W-1:0]  MAP_SRC  = '0,
  parameter logic [NUM_MAP*PAGE_W-1:0] MAP_PAGE = '0,
  parameter logic [PAGE_W-1:0]         DFLT_PAGE = '0
) (
  input  logic [SRC_W-1:0]  src_i,
  output logic [PAGE_W-1:0] page_o
);
  logic [NUM_MAP-1:0] hit;

  // one comparator per table entry
  for (genvar g = 0; g < NUM_MAP; g++) begin : g_cmp
    assign hit[g] = (src_i == MAP_SRC[g*SRC_W +: SRC_W]);
  end

  // lowest matching entry wins; no match falls back to the default page
  always_comb begin
    page_o = DFLT_PAGE;
    for (int i = NUM_MAP - 1; i >= 0; i--) begin
      if (hit[i]) page_o = MAP_PAGE[i*PAGE_W +: PAGE_W];
    end
  end
endmodule

// File: rtl/pgstk_ctrl.sv
module pgstk_ctrl
  import pgstk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stk_en_i,
  input  logic             irq_take_i,
  input  logic             ret_i,
  input  logic             sw_wr_i,
  input  logic [SEL_W-1:0] sw_lvl_i,
  output stk_op_e          op_o,
  output logic [LVLS-1:0]  wr_en_o
);
  logic push_req;
  assign push_req = irq_take_i & stk_en_i;

  always_comb begin
    unique case ({push_req, ret_i})
      2'b10:   op_o = OP_PUSH;
      2'b01:   op_o = OP_POP;
      2'b11:   op_o = OP_SWAP;
      default: op_o = OP_HOLD;
    endcase
  end

  // software writes only land in cycles with no stack motion
  for (genvar g = 0; g < LVLS; g++) begin : g_wr
    assign wr_en_o[g] = (op_o == OP_HOLD) && sw_wr_i && (sw_lvl_i == SEL_W'(g));
  end

  // R8
  wr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en_o));

  // R9
  wr_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_take_i && stk_en_i) || ret_i |-> wr_en_o == '0);
endmodule

// File: rtl/pgstk_cell.sv
module pgstk_cell
  import pgstk_pkg::*;
#(
  parameter int unsigned PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  stk_op_e           op_i,
  input  logic [PAGE_W-1:0] push_d_i,
  input  logic [PAGE_W-1:0] pop_d_i,
  input  logic [PAGE_W-1:0] swap_d_i,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] wdata_i,
  output logic [PAGE_W-1:0] q_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else begin
      unique case (op_i)
        OP_PUSH: q_o <= push_d_i;
        OP_POP:  q_o <= pop_d_i;
        OP_SWAP: q_o <= swap_d_i;
        default: if (wr_i) q_o <= wdata_i;
      endcase
    end
  end
endmodule

// File: rtl/pgstk_top.sv
module pgstk_top
  import pgstk_pkg::*;
#(
  parameter int unsigned SRC_W   = 4,
  parameter int unsigned PAGE_W  = 8,
  parameter int unsigned NUM_MAP = 4,
  parameter logic [NUM_MAP*SRC_W-1:0]  MAP_SRC   = {4'd9, 4'd7, 4'd5, 4'd3},
  parameter logic [NUM_MAP*PAGE_W-1:0] MAP_PAGE  = {8'h0F, 8'h2A, 8'h00, 8'h0C},
  parameter logic [PAGE_W-1:0]         DFLT_PAGE = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stk_en_i,
  input  logic              irq_take_i,
  input  logic [SRC_W-1:0]  irq_src_i,
  input  logic              ret_i,
  input  logic              sw_wr_i,
  input  logic [SEL_W-1:0]  sw_lvl_i,
  input  logic [PAGE_W-1:0] sw_data_i,
  output logic [PAGE_W-1:0] page_act_o,
  output logic [PAGE_W-1:0] page_nxt_o,
  output logic [PAGE_W-1:0] page_lst_o
);
  localparam int unsigned TOP = 0;
  localparam int unsigned BOT = LVLS - 1;

  stk_op_e           op;
  logic [LVLS-1:0]   wr_en;
  logic [PAGE_W-1:0] src_page;
  logic [PAGE_W-1:0] lvl_q [LVLS];

  pgstk_lut #(
    .SRC_W(SRC_W), .PAGE_W(PAGE_W), .NUM_MAP(NUM_MAP),
    .MAP_SRC(MAP_SRC), .MAP_PAGE(MAP_PAGE), .DFLT_PAGE(DFLT_PAGE)
  ) u_lut (
    .src_i (irq_src_i),
    .page_o(src_page)
  );

  pgstk_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stk_en_i  (stk_en_i),
    .irq_take_i(irq_take_i),
    .ret_i     (ret_i),
    .sw_wr_i   (sw_wr_i),
    .sw_lvl_i  (sw_lvl_i),
    .op_o      (op),
    .wr_en_o   (wr_en)
  );

  for (genvar g = 0; g < LVLS; g++) begin : g_lvl
    logic [PAGE_W-1:0] push_d, pop_d, swap_d;
    if (g == TOP) begin : g_top
      assign push_d = src_page;
      assign swap_d = src_page;
    end else begin : g_low
      assign push_d = lvl_q[g-1];
      assign swap_d = lvl_q[g];
    end
    if (g == BOT) begin : g_bot
      assign pop_d = lvl_q[g];
    end else begin : g_upper
      assign pop_d = lvl_q[g+1];
    end

    pgstk_cell #(.PAGE_W(PAGE_W)) u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .op_i    (op),
      .push_d_i(push_d),
      .pop_d_i (pop_d),
      .swap_d_i(swap_d),
      .wr_i    (wr_en[g]),
      .wdata_i (sw_data_i),
      .q_o     (lvl_q[g])
    );
  end

  assign page_act_o = lvl_q[0];
  assign page_nxt_o = lvl_q[1];
  assign page_lst_o = lvl_q[2];

  // R3
  push_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_i && stk_en_i && !ret_i |=>
      page_act_o == $past(src_page) && page_nxt_o == $past(page_act_o)
      && page_lst_o == $past(page_nxt_o));

  // R4
  pop_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i && !(irq_take_i && stk_en_i) |=>
      page_act_o == $past(page_nxt_o) && page_nxt_o == $past(page_lst_o)
      && page_lst_o == $past(page_lst_o));

  // R6
  push_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_i && !stk_en_i && !ret_i && !sw_wr_i |=>
      $stable(page_act_o) && $stable(page_nxt_o) && $stable(page_lst_o));

  // R7
  swap_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_i && stk_en_i && ret_i |=>
      page_act_o == $past(src_page) && $stable(page_nxt_o) && $stable(page_lst_o));

  // R8
  sw_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_wr_i && !irq_take_i && !ret_i && sw_lvl_i == 2'd1 |=>
      page_nxt_o == $past(sw_data_i) && $stable(page_act_o) && $stable(page_lst_o));
endmodule

// File: tb/tb_pgstk_top.sv
`timescale 1ns/1ps
module tb_pgstk_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1, irq = 1'b0, ret = 1'b0, wr = 1'b0;
  logic [3:0] src = '0;
  logic [1:0] lvl = '0;
  logic [7:0] wd = '0;
  logic [7:0] act, nxt, lst;
  logic [7:0] ea, en_x, el;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pgstk_top dut (
    .clk_i(clk), .rst_ni(rst_n), .stk_en_i(en), .irq_take_i(irq),
    .irq_src_i(src), .ret_i(ret), .sw_wr_i(wr), .sw_lvl_i(lvl),
    .sw_data_i(wd), .page_act_o(act), .page_nxt_o(nxt), .page_lst_o(lst)
  );

  function automatic logic [7:0] map_of(input logic [3:0] s);
    case (s)
      4'd3: return 8'h0C;
      4'd5: return 8'h00;
      4'd7: return 8'h2A;
      4'd9: return 8'h0F;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] a0, a1, a2,
                       input logic [7:0] e0, e1, e2);
    total++;
    if (a0 !== e0 || a1 !== e1 || a2 !== e2) begin
      bad++;
      $display("FAIL %s: actual act=%h nxt=%h lst=%h expected act=%h nxt=%h lst=%h",
               req, a0, a1, a2, e0, e1, e2);
    end
  endtask

  task automatic step(input logic i_irq, input logic [3:0] i_src, input logic i_ret,
                      input logic i_wr, input logic [1:0] i_lvl, input logic [7:0] i_wd);
    irq = i_irq; src = i_src; ret = i_ret; wr = i_wr; lvl = i_lvl; wd = i_wd;
    @(posedge clk); #1;
    irq = 1'b0; ret = 1'b0; wr = 1'b0;
  endtask

  task automatic load(input logic [7:0] a, input logic [7:0] n, input logic [7:0] l);
    step(0, 0, 0, 1, 2'd0, a);
    step(0, 0, 0, 1, 2'd1, n);
    step(0, 0, 0, 1, 2'd2, l);
    ea = a; en_x = n; el = l;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 in reset", act, nxt, lst, 8'h00, 8'h00, 8'h00);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after reset", act, nxt, lst, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_map();
    logic [3:0] ids [6] = '{4'd3, 4'd5, 4'd7, 4'd9, 4'd0, 4'd14};
    for (int k = 0; k < 6; k++) begin
      load(8'h55, 8'h66, 8'h77);
      step(1, ids[k], 0, 0, 0, 0);
      check($sformatf("R2 src %0d", ids[k]), act, nxt, lst, map_of(ids[k]), 8'h55, 8'h66);
    end
  endtask

  task automatic t_push_pop();
    load(8'h11, 8'h22, 8'h33);
    step(1, 4'd3, 0, 0, 0, 0);
    check("R3 push", act, nxt, lst, 8'h0C, 8'h11, 8'h22);
    step(0, 0, 1, 0, 0, 0);
    check("R4 pop", act, nxt, lst, 8'h11, 8'h22, 8'h22);
    step(0, 0, 1, 0, 0, 0);
    check("R4 second pop, last kept", act, nxt, lst, 8'h22, 8'h22, 8'h22);
  endtask

  task automatic t_nested();
    load(8'h40, 8'h41, 8'h42);
    step(1, 4'd7, 0, 0, 0, 0);
    step(1, 4'd9, 0, 0, 0, 0);
    check("R5 nested depth 2", act, nxt, lst, 8'h0F, 8'h2A, 8'h40);
    step(0, 0, 1, 0, 0, 0);
    check("R5 first return", act, nxt, lst, 8'h2A, 8'h40, 8'h40);
    step(0, 0, 1, 0, 0, 0);
    check("R5 second return", act, nxt, lst, 8'h40, 8'h40, 8'h40);
  endtask

  task automatic t_disable();
    load(8'h91, 8'h92, 8'h93);
    en = 1'b0;
    step(1, 4'd3, 0, 0, 0, 0);
    check("R6 push gated", act, nxt, lst, 8'h91, 8'h92, 8'h93);
    step(1, 4'd9, 1, 0, 0, 0);
    check("R7 gated push with return pops only", act, nxt, lst, 8'h92, 8'h93, 8'h93);
    en = 1'b1;
  endtask

  task automatic t_swap();
    load(8'hA1, 8'hA2, 8'hA3);
    step(1, 4'd7, 1, 0, 0, 0);
    check("R7 push with return", act, nxt, lst, 8'h2A, 8'hA2, 8'hA3);
  endtask

  task automatic t_swrite();
    load(8'hB1, 8'hB2, 8'hB3);
    check("R8 writes to levels 0..2", act, nxt, lst, 8'hB1, 8'hB2, 8'hB3);
    step(0, 0, 0, 1, 2'd3, 8'hEE);
    check("R8 select 3 ignored", act, nxt, lst, 8'hB1, 8'hB2, 8'hB3);
    step(0, 0, 0, 1, 2'd2, 8'hC3);
    check("R8 write last only", act, nxt, lst, 8'hB1, 8'hB2, 8'hC3);
  endtask

  task automatic t_collide();
    load(8'hD1, 8'hD2, 8'hD3);
    step(1, 4'd3, 0, 1, 2'd2, 8'hEE);
    check("R9 write during push", act, nxt, lst, 8'h0C, 8'hD1, 8'hD2);
    step(0, 0, 1, 1, 2'd0, 8'hEE);
    check("R9 write during pop", act, nxt, lst, 8'hD1, 8'hD2, 8'hD2);
  endtask

  initial begin
    t_reset();
    t_map();
    t_push_pop();
    t_nested();
    t_disable();
    t_swap();
    t_swrite();
    t_collide();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule